// File: doc/BRIEF.md
# Aligned bytecode fetch unit

The unit reads a stream of byte-coded instructions out of a 16-bit word memory and hands them one at a time to an execute stage. Each instruction is an opcode byte followed by zero, one or two operand bytes. A byte program counter selects the current byte, and a one-word buffer holds the last word read. An external classifier looks at each opcode and reports its length and whether it is aligned. Non-aligned instructions are gathered byte by byte and may cross a word boundary. Aligned instructions follow word-placement rules, so pad bytes are skipped and a dedicated no-op byte fills gaps.

Instructions leave through a valid/ready port. A jump input reloads the program counter, flushes the word buffer and drops any partly or fully assembled instruction. An aligned two-byte instruction placed on an odd byte is reported as an alignment fault and stops the unit until the next jump.

Top module: `abf_fetch`

## Requirements
- R1: Byte address p lives in word p>>1. An even address selects bits [7:0] of the word and an odd address selects bits [15:8]. A non-aligned instruction takes its bytes from consecutive addresses, and may span two words.
- R2: Every opcode byte is shown on `cls_opcode`. A length code of 0 is treated as 1. An issued instruction carries its opcode, its length (1 to 3) and its operand bytes, and an operand byte it does not use reads 0.
- R3: An aligned one-byte opcode at an even address also consumes the odd byte of its word, so the next opcode is fetched from the following word.
- R4: An aligned two-byte opcode at an odd address raises `align_fault` for one cycle and is not issued. No instruction is issued after that until a jump.
- R5: For an aligned three-byte opcode, both operands come from the word after the opcode's word: `ins_arg0` is that word's odd byte and `ins_arg1` is its even byte. The next opcode follows at the start of the word after that one.
- R6: The no-op byte (parameter `NOP_OP`, 8'hFF by default) is tested before classification. It is consumed without being issued, and the address advances by one.
- R7: While `ins_valid` is high, `ins_ready` is low and no jump arrives, the output instruction stays unchanged and valid.
- R8: While `jmp_valid` is high, `ins_valid` is low. The program counter takes `jmp_addr` at that edge. Buffered data and any read still in flight are discarded. The next instruction issued is the one at the target.
- R9: At most one memory read is outstanding. No new request is made until the previous response has returned.
- R10: During reset no instruction is valid, and fetching begins with a request for word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jmp_valid | input | 1 | Load a new byte address |
| jmp_addr | input | PC_W | Target byte address |
| mem_req | output | 1 | Word read request |
| mem_addr | output | PC_W-1 | Word address of the request |
| mem_rvalid | input | 1 | Returned word is valid |
| mem_rdata | input | 16 | Returned word |
| cls_opcode | output | 8 | Opcode byte sent to the classifier |
| cls_len | input | 2 | Instruction length from the classifier |
| cls_aligned | input | 1 | Aligned flag from the classifier |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Execute stage accepts the instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_arg0 | output | 8 | First operand byte |
| ins_arg1 | output | 8 | Second operand byte |
| ins_len | output | 2 | Instruction length |
| align_fault | output | 1 | Aligned two-byte opcode found at an odd address |

## Verification
The assertions rely on the following input behaviour:
- Memory returns exactly one response for each request, never answers without a request, and never answers in the same cycle as the request.
- The classifier answers combinationally from `cls_opcode`.

The bench memory model follows these rules. It keeps a single read in flight, with a latency of one to four cycles chosen per trial. It only rewrites memory contents between trials, while the output port is not being watched. Each trial ends with a jump, which may land while a read is still pending, so stale returns get exercised.

// File: rtl/abf_pkg.sv
package abf_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ARG0,
    ST_ARG1,
    ST_WORD,
    ST_ISSUE,
    ST_HALT
  } seq_st_e;

  // pick one byte lane of a 16-bit word: odd address -> upper lane
  function automatic logic [7:0] lane_pick(input logic [15:0] w, input logic odd);
    return odd ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/abf_wordbuf.sv
module abf_wordbuf #(
  parameter int WA_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            need,
  input  logic [WA_W-1:0] need_addr,
  input  logic            flush,
  output logic            hit,
  output logic [15:0]     word,
  output logic            mem_req,
  output logic [WA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [15:0]     mem_rdata
);

  logic            vld_q, vld_d;
  logic            pend_q, pend_d;
  logic            stale_q, stale_d;
  logic [WA_W-1:0] tag_q, rtag_q;
  logic [15:0]     word_q;
  logic            ld_word;

  assign hit      = vld_q && (tag_q == need_addr);
  assign word     = word_q;
  assign mem_req  = need && !hit && !pend_q && !flush;
  assign mem_addr = need_addr;
  assign ld_word  = mem_rvalid && !stale_q && !flush;

  always_comb begin
    vld_d   = vld_q;
    pend_d  = pend_q;
    stale_d = stale_q;
    if (mem_rvalid) begin
      pend_d  = 1'b0;
      stale_d = 1'b0;
    end
    if (ld_word) vld_d = 1'b1;
    if (flush) begin
      vld_d = 1'b0;
      if (pend_q && !mem_rvalid) stale_d = 1'b1;
    end
    if (mem_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      tag_q   <= '0;
      rtag_q  <= '0;
      word_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      pend_q  <= pend_d;
      stale_q <= stale_d;
      if (mem_req) rtag_q <= need_addr;
      if (ld_word) begin
        tag_q  <= rtag_q;
        word_q <= mem_rdata;
      end
    end
  end

  // R9: a request is never followed directly by another one
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R9: a response only arrives for a request in flight (input assumption)
  a_r9_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> pend_q);

endmodule

// File: rtl/abf_seq.sv
module abf_seq
  import abf_pkg::*;
#(
  parameter int         PC_W   = 16,
  parameter logic [7:0] NOP_OP = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jmp_valid,
  input  logic [PC_W-1:0] jmp_addr,
  output logic            need,
  output logic [PC_W-2:0] need_addr,
  input  logic            hit,
  input  logic [15:0]     word,
  output logic [7:0]      cls_opcode,
  input  logic [1:0]      cls_len,
  input  logic            cls_aligned,
  output logic            ins_valid,
  input  logic            ins_ready,
  output logic [7:0]      ins_opcode,
  output logic [7:0]      ins_arg0,
  output logic [7:0]      ins_arg1,
  output logic [1:0]      ins_len,
  output logic            align_fault
);

  localparam int              WA_W  = PC_W - 1;
  localparam logic [PC_W-1:0] PC_1  = PC_W'(1);
  localparam logic [PC_W-1:0] PC_2  = PC_W'(2);
  localparam logic [WA_W-1:0] WA_1  = WA_W'(1);

  seq_st_e         st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [7:0]      opc_q, opc_d, a0_q, a0_d, a1_q, a1_d;
  logic [1:0]      len_q, len_d;
  logic            alg_q, alg_d;
  logic [7:0]      cur_byte;
  logic [1:0]      eff_len;
  logic            is_nop;

  assign cur_byte    = lane_pick(word, pc_q[0]);
  assign cls_opcode  = cur_byte;
  assign eff_len     = (cls_len == 2'd0) ? 2'd1 : cls_len;
  assign is_nop      = (cur_byte == NOP_OP);
  assign need        = (st_q == ST_OPC) || (st_q == ST_ARG0) ||
                       (st_q == ST_ARG1) || (st_q == ST_WORD);
  assign need_addr   = pc_q[PC_W-1:1];
  assign ins_valid   = (st_q == ST_ISSUE) && !jmp_valid;
  assign align_fault = (st_q == ST_OPC) && hit && !jmp_valid && !is_nop &&
                       (eff_len == 2'd2) && cls_aligned && pc_q[0];
  assign ins_opcode  = opc_q;
  assign ins_arg0    = a0_q;
  assign ins_arg1    = a1_q;
  assign ins_len     = len_q;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    opc_d = opc_q;
    a0_d  = a0_q;
    a1_d  = a1_q;
    len_d = len_q;
    alg_d = alg_q;
    if (jmp_valid) begin
      st_d = ST_OPC;
      pc_d = jmp_addr;
    end else begin
      case (st_q)
        ST_OPC: if (hit) begin
          if (is_nop) begin
            pc_d = pc_q + PC_1;
          end else begin
            opc_d = cur_byte;
            a0_d  = '0;
            a1_d  = '0;
            len_d = eff_len;
            alg_d = cls_aligned;
            case (eff_len)
              2'd2: begin
                if (cls_aligned && pc_q[0]) begin
                  st_d = ST_HALT;
                end else begin
                  pc_d = pc_q + PC_1;
                  st_d = ST_ARG0;
                end
              end
              2'd3: begin
                if (cls_aligned) begin
                  pc_d = {pc_q[PC_W-1:1] + WA_1, 1'b0};
                  st_d = ST_WORD;
                end else begin
                  pc_d = pc_q + PC_1;
                  st_d = ST_ARG0;
                end
              end
              default: begin
                pc_d = pc_q + ((cls_aligned && !pc_q[0]) ? PC_2 : PC_1);
                st_d = ST_ISSUE;
              end
            endcase
          end
        end
        ST_ARG0: if (hit) begin
          a0_d = cur_byte;
          pc_d = pc_q + PC_1;
          st_d = (len_q == 2'd3) ? ST_ARG1 : ST_ISSUE;
        end
        ST_ARG1: if (hit) begin
          a1_d = cur_byte;
          pc_d = pc_q + PC_1;
          st_d = ST_ISSUE;
        end
        ST_WORD: if (hit) begin
          a0_d = word[15:8];
          a1_d = word[7:0];
          pc_d = pc_q + PC_2;
          st_d = ST_ISSUE;
        end
        ST_ISSUE: if (ins_ready) st_d = ST_OPC;
        ST_HALT: st_d = ST_HALT;
        default: st_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OPC;
      pc_q  <= '0;
      opc_q <= '0;
      a0_q  <= '0;
      a1_q  <= '0;
      len_q <= 2'd1;
      alg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      opc_q <= opc_d;
      a0_q  <= a0_d;
      a1_q  <= a1_d;
      len_q <= len_d;
      alg_q <= alg_d;
    end
  end

  // R7: a stalled instruction stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !jmp_valid) |=>
      ((ins_valid || jmp_valid) && $stable(ins_opcode) && $stable(ins_arg0) &&
       $stable(ins_arg1) && $stable(ins_len)));

  // R4: after a fault nothing is issued
  a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |=> !ins_valid);

  // R3 / R5: an aligned instruction always leaves the counter on a word start
  a_r3_word_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ISSUE) && alg_q) |-> !pc_q[0]);

  // R8: a jump loads the counter
  a_r8_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> (pc_q == $past(jmp_addr)));

endmodule

// File: rtl/abf_fetch.sv
module abf_fetch #(
  parameter int         PC_W   = 16,
  parameter logic [7:0] NOP_OP = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jmp_valid,
  input  logic [PC_W-1:0] jmp_addr,
  output logic            mem_req,
  output logic [PC_W-2:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [15:0]     mem_rdata,
  output logic [7:0]      cls_opcode,
  input  logic [1:0]      cls_len,
  input  logic            cls_aligned,
  output logic            ins_valid,
  input  logic            ins_ready,
  output logic [7:0]      ins_opcode,
  output logic [7:0]      ins_arg0,
  output logic [7:0]      ins_arg1,
  output logic [1:0]      ins_len,
  output logic            align_fault
);

  localparam int WA_W = PC_W - 1;

  logic            need, hit;
  logic [WA_W-1:0] need_addr;
  logic [15:0]     word;

  abf_wordbuf #(.WA_W(WA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .need       (need),
    .need_addr  (need_addr),
    .flush      (jmp_valid),
    .hit        (hit),
    .word       (word),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  abf_seq #(.PC_W(PC_W), .NOP_OP(NOP_OP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .jmp_valid   (jmp_valid),
    .jmp_addr    (jmp_addr),
    .need        (need),
    .need_addr   (need_addr),
    .hit         (hit),
    .word        (word),
    .cls_opcode  (cls_opcode),
    .cls_len     (cls_len),
    .cls_aligned (cls_aligned),
    .ins_valid   (ins_valid),
    .ins_ready   (ins_ready),
    .ins_opcode  (ins_opcode),
    .ins_arg0    (ins_arg0),
    .ins_arg1    (ins_arg1),
    .ins_len     (ins_len),
    .align_fault (align_fault)
  );

endmodule

// File: tb/tb_abf_fetch.sv
module tb_abf_fetch;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 8;
  localparam int WA_W   = PC_W - 1;
  localparam int WORDS  = 1 << WA_W;
  localparam int PCMASK = (1 << PC_W) - 1;
  localparam logic [7:0] NOP = 8'hFF;
  localparam int TRIALS = 250;
  localparam int PER_TRIAL = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            jmp_valid = 1'b0;
  logic [PC_W-1:0] jmp_addr = '0;
  logic            mem_req;
  logic [WA_W-1:0] mem_addr;
  logic            mem_rvalid = 1'b0;
  logic [15:0]     mem_rdata = '0;
  logic [7:0]      cls_opcode;
  logic [1:0]      cls_len;
  logic            cls_aligned;
  logic            ins_valid;
  logic            ins_ready = 1'b0;
  logic [7:0]      ins_opcode, ins_arg0, ins_arg1;
  logic [1:0]      ins_len;
  logic            align_fault;

  // classifier model: bits [1:0] length code, bit 2 aligned flag
  assign cls_len     = cls_opcode[1:0];
  assign cls_aligned = cls_opcode[2];

  abf_fetch #(.PC_W(PC_W), .NOP_OP(NOP)) dut (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_addr(jmp_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cls_opcode(cls_opcode), .cls_len(cls_len), .cls_aligned(cls_aligned),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_opcode(ins_opcode),
    .ins_arg0(ins_arg0), .ins_arg1(ins_arg1), .ins_len(ins_len), .align_fault(align_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [WORDS];
  int unsigned seed = 32'h1234_5678;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit tracking = 0;
  bit halted = 0;
  bit first = 0;
  int ref_pc = 0;
  int issued = 0;
  int lat_cfg = 0;
  int ready_lvl = 4;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    logic [15:0] w;
    w = mem[(a & PCMASK) >> 1];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  // model of the requirements: returns {op,arg0,arg1,6'b0,len}
  function automatic void ref_step(input int pc_in, output logic [31:0] expv,
                                   output int npc, output bit fault, output int kind);
    int pc;
    int l;
    int w;
    bit al;
    logic [7:0] b, a0, a1;
    pc = pc_in; fault = 0; kind = 0; a0 = 0; a1 = 0;
    for (int g = 0; g < 256 && mbyte(pc) == NOP; g++) begin
      pc = (pc + 1) & PCMASK;
      kind = 6;
    end
    b = mbyte(pc);
    l = int'(b[1:0]);
    if (l == 0) l = 1;
    al = b[2];
    if (l == 1) begin
      if (al && pc % 2 == 0) begin npc = pc + 2; kind = 3; end
      else npc = pc + 1;
    end else if (l == 2) begin
      if (al && pc % 2 == 1) fault = 1;
      a0 = mbyte(pc + 1);
      npc = pc + 2;
      if (pc % 2 == 1 && kind == 0) kind = 1;
    end else if (al) begin
      w = ((pc >> 1) + 1) & (WORDS - 1);
      a0 = mem[w][15:8];
      a1 = mem[w][7:0];
      npc = (w + 1) * 2;
      kind = 5;
    end else begin
      a0 = mbyte(pc + 1);
      a1 = mbyte(pc + 2);
      npc = pc + 3;
      if (kind == 0) kind = 1;
    end
    npc = npc & PCMASK;
    expv = {b, a0, a1, 6'b0, 2'(l)};
  endfunction

  function automatic string tag_of(input int kind, input bit fst);
    if (fst) return "R8 first after jump";
    case (kind)
      1: return "R1 straddling bytes";
      3: return "R3 aligned one-byte";
      5: return "R5 aligned three-byte";
      6: return "R6 no-op skipped";
      default: return "R2 instruction fields";
    endcase
  endfunction

  // memory model: one read in flight, latency lat_cfg+1 cycles
  initial begin
    int cnt;
    bit outst;
    logic [WA_W-1:0] raddr;
    cnt = 0; outst = 0; raddr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_rvalid = 1'b0; cnt = 0; outst = 0;
      end else begin
        if (mem_rvalid) begin mem_rvalid = 1'b0; outst = 0; end
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = mem[raddr]; end
        end
        if (mem_req) begin
          chk(!outst, "R9 single outstanding read", 32'(outst), 0);
          if (!outst) begin outst = 1; raddr = mem_addr; cnt = lat_cfg + 1; end
        end
      end
    end
  end

  // ready driver
  initial forever begin
    @(posedge clk);
    #2;
    ins_ready = tracking && !jmp_valid && ((rnd() % 4) < ready_lvl);
  end

  // output monitor
  initial begin
    bit hold_p;
    logic [31:0] hold_v, act, expv;
    int npc, kind;
    bit rf;
    hold_p = 0; hold_v = 0;
    forever begin
      @(negedge clk);
      if (!tracking || !rst_n) begin
        hold_p = 0;
      end else begin
        act = {ins_opcode, ins_arg0, ins_arg1, 6'b0, ins_len};
        if (jmp_valid) chk(ins_valid == 1'b0, "R8 no issue during jump", 32'(ins_valid), 0);
        if (hold_p && ins_valid) chk(act == hold_v, "R7 stalled output held", act, hold_v);
        hold_p = 0;
        if (ins_valid && ins_ready) begin
          ref_step(ref_pc, expv, npc, rf, kind);
          if (rf) chk(0, "R4 fault expected, issue seen", act, expv);
          else chk(act == expv, tag_of(kind, first), act, expv);
          ref_pc = npc;
          issued++;
          first = 0;
        end else if (ins_valid) begin
          hold_p = 1;
          hold_v = act;
        end
        if (align_fault && !halted) begin
          ref_step(ref_pc, expv, npc, rf, kind);
          chk(rf, "R4 fault raised", 32'(align_fault), 32'(rf));
          halted = 1;
        end
      end
    end
  end

  task automatic run_trial();
    int target;
    int cyc;
    @(posedge clk);
    #1;
    tracking = 0;
    for (int w = 0; w < WORDS; w++) begin
      logic [7:0] lo, hi;
      lo = (rnd() % 8 == 0) ? NOP : 8'(rnd() >> 4);
      hi = (rnd() % 8 == 0) ? NOP : 8'(rnd() >> 4);
      mem[w] = {hi, lo};
    end
    lat_cfg   = int'(rnd() % 4);
    ready_lvl = 1 + int'(rnd() % 4);
    target    = int'(rnd() % (PCMASK + 1));
    ref_pc = target; first = 1; halted = 0; issued = 0;
    jmp_addr  = PC_W'(target);
    jmp_valid = 1'b1;
    tracking  = 1;
    @(posedge clk);
    #1;
    jmp_valid = 1'b0;
    cyc = 0;
    while (issued < PER_TRIAL && !halted && cyc < 2000) begin
      @(posedge clk);
      #1;
      cyc++;
    end
    if (!halted && issued < PER_TRIAL) chk(0, "R2 fetch progress", 32'(issued), PER_TRIAL);
    if (halted) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(ins_valid == 1'b0, "R4 halted until jump", 32'(ins_valid), 0);
      end
    end
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) mem[w] = 16'h0101;
    repeat (3) @(negedge clk);
    chk(ins_valid == 1'b0, "R10 no instruction in reset", 32'(ins_valid), 0);
    chk(mem_req == 1'b1, "R10 fetch request in reset", 32'(mem_req), 1);
    chk(mem_addr == '0, "R10 fetch starts at word 0", 32'(mem_addr), 0);
    chk(align_fault == 1'b0, "R10 no fault in reset", 32'(align_fault), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int t = 0; t < TRIALS; t++) run_trial();
    @(posedge clk);
    #1;
    tracking = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule